// File: doc/BRIEF.md
# Exclusive access monitor

This block tracks one bus master's exclusive reservations. A load-exclusive request records which word it touched and how wide the access was, and moves the monitor from open to exclusive. A later store-exclusive is let through to memory only when the monitor is still exclusive and the store matches the recorded word and width. In every other case the store is held back. The requester gets a one-bit result: 0 when the store went through and 1 when it was refused. Software retries the whole read-modify-write sequence when it sees 1.

Ordinary stores always reach memory. An ordinary store to the reserved word also drops the reservation. A clear input lets the surrounding core drop the reservation at any time, for example on an exception boundary. Only one of the three request flags may be high in a cycle. If more than one is high, the priority is store-exclusive, then load-exclusive, then ordinary store.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open, `mem_wr_en` is 0 while no request is present, `sx_done` is 0 and `sx_fail` is 0.
- R2: A load-exclusive followed by a store-exclusive to the same word with the same size raises `mem_wr_en` in the store's request cycle. One cycle later `sx_done` is 1 and `sx_fail` is 0.
- R3: A store-exclusive issued while the monitor is open keeps `mem_wr_en` at 0 and reports `sx_fail` = 1.
- R4: The address is compared on bits [ADDR_W-1:2]. A store-exclusive that differs only in bits [1:0] succeeds. A difference in any higher bit makes it fail.
- R5: The size encoding is 0 = byte, 1 = halfword, 2 = word. A store-exclusive whose size differs from the one recorded by the load-exclusive fails.
- R6: Every store-exclusive returns the monitor to open, whether it succeeds or fails, so a second store-exclusive without a new load-exclusive fails.
- R7: `mon_clear` forces the monitor open. A load-exclusive in the same cycle as `mon_clear` does not arm it. A store-exclusive in the same cycle as `mon_clear` fails.
- R8: An ordinary store always raises `mem_wr_en`. When it hits the reserved word it opens the monitor. When it hits a different word it leaves the reservation untouched.
- R9: A new load-exclusive replaces the recorded address and size.
- R10: `sx_done` is a one-cycle pulse that follows each store-exclusive request and no other request.
- R11: Reservations work at byte, halfword and word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_ldx | input | 1 | Load-exclusive request |
| req_stx | input | 1 | Store-exclusive request |
| req_st | input | 1 | Ordinary store request |
| mon_clear | input | 1 | Force the monitor open |
| mem_wr_en | output | 1 | Write enable to memory, same cycle as the request |
| sx_done | output | 1 | Store-exclusive result strobe, one cycle after the request |
| sx_fail | output | 1 | Store-exclusive result: 0 granted, 1 refused |

## Verification
The write enable is combinational, so the bench reads it in the same cycle it drives a request, once the inputs have settled. The store-exclusive result passes through one register. For each store-exclusive the driver queues the expected result. The monitor process takes an item off the queue only on the falling edge after `sx_done` is seen, which is one rising edge after the request. A `sx_done` that arrives with an empty queue, or that is missing when a result is due, counts as a mismatch, and this enforces the one-cycle latency and the single-pulse width.

// File: rtl/excl_mon_pkg.sv
// Shared types for the exclusive access monitor.
package excl_mon_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        MON_OPEN = 1'b0,
        MON_EXCL = 1'b1
    } mon_state_e;
endpackage

// File: rtl/excl_tag_reg.sv
// Holds the monitor state and the reserved word tag and access size.
// Assumes open_i and set_i are never both asserted; open_i wins if they are.
module excl_tag_reg
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             open_i,
    input  logic [TAG_W-1:0] tag_i,
    input  acc_size_e        size_i,
    output mon_state_e       state_o,
    output logic [TAG_W-1:0] tag_o,
    output acc_size_e        size_o
);
    // State transition: open on request, arm and capture tag on load-exclusive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= MON_OPEN;
            tag_o   <= '0;
            size_o  <= SZ_BYTE;
        end else if (open_i) begin
            state_o <= MON_OPEN;
        end else if (set_i) begin
            state_o <= MON_EXCL;
            tag_o   <= tag_i;
            size_o  <= size_i;
        end
    end
endmodule

// File: rtl/excl_match.sv
// Compares a request against the stored reservation.
// word_hit ignores size (used by ordinary stores); grant needs size equality too.
module excl_match
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  mon_state_e       state_i,
    input  logic [TAG_W-1:0] rsv_tag_i,
    input  acc_size_e        rsv_size_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  acc_size_e        req_size_i,
    output logic             word_hit_o,
    output logic             grant_o
);
    // Combinational tag and size comparison.
    always_comb begin
        word_hit_o = (state_i == MON_EXCL) && (rsv_tag_i == req_tag_i);
        grant_o    = word_hit_o && (rsv_size_i == req_size_i);
    end
endmodule

// File: rtl/excl_status_reg.sv
// Registers the store-exclusive outcome: a done pulse and the fail bit.
// sx_fail holds its last value between store-exclusives.
module excl_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic stx_i,
    input  logic pass_i,
    output logic done_o,
    output logic fail_o
);
    // One-cycle result strobe and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            done_o <= stx_i;
            if (stx_i) fail_o <= !pass_i;
        end
    end
endmodule

// File: rtl/excl_monitor.sv
// Local exclusive monitor for one bus master. It gates store-exclusive writes
// and reports the outcome one cycle later. Assumes at most one request flag
// per cycle; otherwise the priority is store-exclusive, load-exclusive, store.
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_ldx,
    input  logic              req_stx,
    input  logic              req_st,
    input  logic              mon_clear,
    output logic              mem_wr_en,
    output logic              sx_done,
    output logic              sx_fail
);
    localparam int TAG_W = ADDR_W - GRAN_LSB;

    logic [TAG_W-1:0] req_tag, rsv_tag;
    acc_size_e        rsv_size, req_sz;
    mon_state_e       mon_state;
    logic             word_hit, grant, sx_pass, do_ldx, do_st, open_now, armed;

    // Decode the request into tag, size and effective operation.
    always_comb begin
        req_tag  = req_addr[ADDR_W-1:GRAN_LSB];
        req_sz   = acc_size_e'(req_size);
        do_ldx   = req_ldx && !req_stx;
        do_st    = req_st && !req_stx && !req_ldx;
        sx_pass  = req_stx && grant && !mon_clear;
        open_now = mon_clear || req_stx || (do_st && word_hit);
        armed    = (mon_state == MON_EXCL);
    end

    // Memory write enable: gated store-exclusive or plain store.
    always_comb begin
        mem_wr_en = sx_pass || do_st;
    end

    excl_tag_reg #(.TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (do_ldx && !mon_clear),
        .open_i (open_now),
        .tag_i  (req_tag),
        .size_i (req_sz),
        .state_o(mon_state),
        .tag_o  (rsv_tag),
        .size_o (rsv_size)
    );

    excl_match #(.TAG_W(TAG_W)) u_match (
        .state_i   (mon_state),
        .rsv_tag_i (rsv_tag),
        .rsv_size_i(rsv_size),
        .req_tag_i (req_tag),
        .req_size_i(req_sz),
        .word_hit_o(word_hit),
        .grant_o   (grant)
    );

    excl_status_reg u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .stx_i (req_stx),
        .pass_i(sx_pass),
        .done_o(sx_done),
        .fail_o(sx_fail)
    );
endmodule

// File: rtl/excl_monitor_chk.sv
// Temporal checks for excl_monitor, attached through bind.
module excl_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic req_stx,
    input logic req_st,
    input logic req_ldx,
    input logic mon_clear,
    input logic armed,
    input logic mem_wr_en,
    input logic sx_done,
    input logic sx_fail
);
    // R10
    done_follows_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sx_done |-> $past(req_stx));
    // R2
    granted_reports_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stx && mem_wr_en) |=> (sx_done && !sx_fail));
    // R3
    refused_reports_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stx && !mem_wr_en) |=> (sx_done && sx_fail));
    // R3
    open_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stx && !armed) |-> !mem_wr_en);
    // R6
    stx_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_stx |=> !armed);
    // R7
    clear_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_clear |=> !armed);
    // R8
    plain_store_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_st && !req_stx && !req_ldx) |-> mem_wr_en);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_stx  (req_stx),
    .req_st   (req_st),
    .req_ldx  (req_ldx),
    .mon_clear(mon_clear),
    .armed    (armed),
    .mem_wr_en(mem_wr_en),
    .sx_done  (sx_done),
    .sx_fail  (sx_fail)
);

// File: tb/sim_excl_monitor.sv
// Scoreboard bench: the driver queues expected store-exclusive results and the
// monitor process compares them when sx_done appears.
module sim_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_ldx = 1'b0, req_stx = 1'b0, req_st = 1'b0, mon_clear = 1'b0;
    logic        mem_wr_en, sx_done, sx_fail;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   exp_q[$];
    string tag_q[$];
    bit   run_on = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    excl_monitor u0 (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_size(req_size),
        .req_ldx(req_ldx), .req_stx(req_stx), .req_st(req_st),
        .mon_clear(mon_clear), .mem_wr_en(mem_wr_en),
        .sx_done(sx_done), .sx_fail(sx_fail)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // kind: 0 idle, 1 load-exclusive, 2 store-exclusive, 3 store
    task automatic op(input int kind, input logic [31:0] a, input logic [1:0] sz,
                      input logic clr, input logic exp_we, input logic exp_fail,
                      input string req);
        @(negedge clk);
        req_addr  = a;
        req_size  = sz;
        req_ldx   = (kind == 1);
        req_stx   = (kind == 2);
        req_st    = (kind == 3);
        mon_clear = clr;
        if (kind == 2) begin
            exp_q.push_back(exp_fail);
            tag_q.push_back(req);
        end
        #1;
        check({req, " write enable"}, mem_wr_en, exp_we);
        @(posedge clk);
        #1;
        req_ldx = 1'b0; req_stx = 1'b0; req_st = 1'b0; mon_clear = 1'b0;
    endtask

    // Monitor: compares each done pulse with the oldest queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (run_on && sx_done) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R10: done got 1 expected 0");
                end else begin
                    check({tag_q.pop_front(), " status"}, sx_fail, exp_q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset write enable", mem_wr_en, 1'b0);
        check("R1 reset done", sx_done, 1'b0);
        check("R1 reset status", sx_fail, 1'b0);
        run_on = 1'b1;

        op(2, 32'h2000_0100, 2'd2, 0, 0, 1, "R3 open stx");
        op(1, 32'h2000_0100, 2'd2, 0, 0, 0, "R2 ldx");
        op(2, 32'h2000_0100, 2'd2, 0, 1, 0, "R2 matching stx");
        op(2, 32'h2000_0100, 2'd2, 0, 0, 1, "R6 second stx");
        op(1, 32'h2000_0100, 2'd1, 0, 0, 0, "R4 ldx half");
        op(2, 32'h2000_0102, 2'd1, 0, 1, 0, "R4 low bits differ");
        op(1, 32'h2000_0100, 2'd2, 0, 0, 0, "R4 ldx");
        op(2, 32'h2000_0104, 2'd2, 0, 0, 1, "R4 other word");
        op(1, 32'h2000_0100, 2'd2, 0, 0, 0, "R5 ldx");
        op(2, 32'h2000_0100, 2'd0, 0, 0, 1, "R5 size mismatch");
        op(1, 32'h2000_0033, 2'd0, 0, 0, 0, "R11 ldx byte");
        op(2, 32'h2000_0033, 2'd0, 0, 1, 0, "R11 byte stx");
        op(1, 32'h2000_0040, 2'd2, 0, 0, 0, "R7 ldx");
        op(0, 32'h0, 2'd0, 1, 0, 0, "R7 clear");
        op(2, 32'h2000_0040, 2'd2, 0, 0, 1, "R7 stx after clear");
        op(1, 32'h2000_0040, 2'd2, 0, 0, 0, "R7 ldx");
        op(2, 32'h2000_0040, 2'd2, 1, 0, 1, "R7 stx with clear");
        op(1, 32'h2000_0040, 2'd2, 1, 0, 0, "R7 ldx with clear");
        op(2, 32'h2000_0040, 2'd2, 0, 0, 1, "R7 stx after ldx with clear");
        op(1, 32'h2000_0200, 2'd2, 0, 0, 0, "R8 ldx");
        op(3, 32'h2000_0204, 2'd2, 0, 1, 0, "R8 store other word");
        op(2, 32'h2000_0200, 2'd2, 0, 1, 0, "R8 stx kept");
        op(1, 32'h2000_0200, 2'd2, 0, 0, 0, "R8 ldx");
        op(3, 32'h2000_0200, 2'd0, 0, 1, 0, "R8 store same word");
        op(2, 32'h2000_0200, 2'd2, 0, 0, 1, "R8 stx lost");
        op(1, 32'h2000_0300, 2'd2, 0, 0, 0, "R9 ldx first");
        op(1, 32'h2000_0400, 2'd2, 0, 0, 0, "R9 ldx second");
        op(2, 32'h2000_0300, 2'd2, 0, 0, 1, "R9 old tag");
        op(1, 32'h2000_0300, 2'd2, 0, 0, 0, "R9 ldx first");
        op(1, 32'h2000_0400, 2'd1, 0, 0, 0, "R9 ldx second");
        op(2, 32'h2000_0400, 2'd1, 0, 1, 0, "R9 new tag");
        op(0, 32'h0, 2'd0, 0, 0, 0, "R10 idle");
        op(0, 32'h0, 2'd0, 0, 0, 0, "R10 idle");
        @(negedge clk);
        check("R10 queue drained", exp_q.size() == 0, 1'b1);
        check("R10 done low", sx_done, 1'b0);
        finished = 1'b1;
        summary();
    end
endmodule